// File: doc/BRIEF.md
# Pipelined Multiplierless Symmetric FIR Filter

This block is a linear-phase FIR filter whose coefficients are fixed when the design is built. It takes one sample per clock on a streaming input qualified by a valid strobe. It delivers one full-precision result per accepted sample on a streaming output that has its own valid strobe. The filter history advances only on accepted samples, so the stream may have idle gaps.

The coefficient set is symmetric, so only half of it is given. The two samples that share a coefficient are first summed, or differenced when the anti-symmetric variant is selected. Each of these pre-combined values is then scaled by its constant. The scaling uses only shifted copies that are added or subtracted, one copy for each nonzero canonical signed digit (CSD) of the coefficient; these digits are derived while the design is elaborated. A registered balanced adder tree sums the products. Every stage boundary carries a register, so the throughput is one result per clock.

Top module: `sym_csd_fir`

## Requirements
- R1: For every cycle in which `in_valid` is high, `out_valid` is high for exactly one cycle, LAT = 3 + ceil(log2(ceil(TAPS/2))) cycles later (6 cycles with the default 16 taps). `out_valid` is never high at any other time.
- R2: With ANTISYM = 0, `out_data` equals the sum over k = 0..TAPS-1 of h[k]·x[n-k]. Here x[n] is the newest accepted sample, and h[k] = h[TAPS-1-k] = COEF[min(k, TAPS-1-k)].
- R3: With ANTISYM = 1, h[k] = COEF[k] and h[TAPS-1-k] = -COEF[k] for k < TAPS/2. The result is otherwise the same sum as in R2.
- R4: A cycle with `in_valid` low neither changes the filter history nor produces an output. Samples separated by idle gaps give the same results as the same samples sent back to back.
- R5: Reset sets every stored sample to zero. The first results after reset therefore equal the convolution of the new samples with an all-zero history.
- R6: `out_valid` is low while reset is asserted and after reset until the first accepted sample has travelled through the pipeline. Samples that were still in flight when reset came are dropped.
- R7: `out_data` is two's complement of width IN_W + CW + 1 + ceil(log2(ceil(TAPS/2))), with no rounding or saturation. Full-scale inputs of either sign produce the exact sum.
- R8: A single accepted sample of value 1, followed by zeros, makes the TAPS consecutive outputs equal h[0], h[1], ..., h[TAPS-1].
- R9: Samples accepted on consecutive clocks produce outputs on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | High when `in_sample` carries a sample to accept |
| in_sample | input | IN_W | Signed input sample, two's complement |
| out_valid | output | 1 | High for one cycle per filtered result |
| out_data | output | IN_W+CW+1+clog2((TAPS+1)/2) | Signed full-precision filter result |

## Verification
The assertions guard several properties on every cycle:
- every output has an accepted sample that produced it, and the number of samples in flight never exceeds the pipeline depth;
- an idle cycle leaves the history untouched, and an accepted sample enters at the head of the history;
- every result stays within the magnitude bound set by the coefficient sum.

The numerical correctness of each result and the exact latency can only be shown by the bench scenarios. These compare every output against a convolution model for impulse, full-scale step, gapped and back-to-back random streams, mid-stream reset, and the anti-symmetric variant.

// File: rtl/sym_csd_fir.sv
module sym_csd_fir #(
  parameter int TAPS = 16,
  parameter int IN_W = 12,
  parameter int CW = 12,
  parameter bit ANTISYM = 1'b0,
  parameter logic signed [CW-1:0] COEF [(TAPS+1)/2] =
    '{12'sd3, -12'sd15, 12'sd0, 12'sd87, -12'sd201, -12'sd2048, 12'sd1023, 12'sd2047}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic signed [IN_W-1:0] in_sample,
  output logic out_valid,
  output logic signed [IN_W+CW+$clog2((TAPS+1)/2):0] out_data
);
  localparam int HALF   = (TAPS + 1) / 2;
  localparam int LEVELS = $clog2(HALF);
  localparam int LEAVES = 1 << LEVELS;
  localparam int PA_W   = IN_W + 1;
  localparam int OUT_W  = PA_W + CW + LEVELS;
  localparam int LAT    = 3 + LEVELS;
  localparam int DIG    = CW + 1;
  localparam int PW     = $clog2(LAT + 2) + 1;

  // Canonical signed digit mask: positive digits (neg=0) or negative digits (neg=1)
  function automatic logic [DIG-1:0] csd_mask(input int c, input bit neg);
    int v;
    int d;
    logic [DIG-1:0] m;
    m = '0;
    v = c;
    for (int i = 0; i < DIG; i++) begin
      d = 0;
      if (v[0]) d = v[1] ? -1 : 1;
      if (neg ? (d < 0) : (d > 0)) m[i] = 1'b1;
      v = (v - d) >>> 1;
    end
    return m;
  endfunction

  function automatic longint out_bound();
    longint s;
    longint c;
    s = 0;
    for (int k = 0; k < HALF; k++) begin
      c = longint'(COEF[k]);
      if (c < 0) c = -c;
      s += (k == TAPS - 1 - k) ? c : 2 * c;
    end
    return s * (longint'(1) << (IN_W - 1));
  endfunction

  localparam longint BOUND = out_bound();

  logic signed [IN_W-1:0]  hist [TAPS];
  logic signed [PA_W-1:0]  pre  [HALF];
  logic signed [OUT_W-1:0] prod [LEAVES];
  logic signed [OUT_W-1:0] lvl  [LEVELS+1][LEAVES];
  logic [LAT-1:0]          vpipe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) hist[i] <= '0;
      vpipe <= '0;
    end else begin
      vpipe <= {vpipe[LAT-2:0], in_valid};
      if (in_valid) begin
        hist[0] <= in_sample;
        for (int i = 1; i < TAPS; i++) hist[i] <= hist[i-1];
      end
    end

  // Fold mirrored taps
  always_ff @(posedge clk)
    for (int k = 0; k < HALF; k++)
      if (k == TAPS - 1 - k) pre[k] <= PA_W'(hist[k]);
      else if (ANTISYM)      pre[k] <= hist[k] - hist[TAPS-1-k];
      else                   pre[k] <= hist[k] + hist[TAPS-1-k];

  // Shift-and-add constant products; zero digits fold away
  for (genvar k = 0; k < LEAVES; k++) begin : g_prod
    if (k < HALF) begin : g_tap
      localparam logic [DIG-1:0] PM = csd_mask(int'(COEF[k]), 1'b0);
      localparam logic [DIG-1:0] NM = csd_mask(int'(COEF[k]), 1'b1);
      logic signed [OUT_W-1:0] acc;
      always_comb begin
        acc = '0;
        for (int i = 0; i < DIG; i++) begin
          if (PM[i]) acc = acc + (OUT_W'(pre[k]) <<< i);
          if (NM[i]) acc = acc - (OUT_W'(pre[k]) <<< i);
        end
      end
      assign prod[k] = acc;
    end else begin : g_pad
      assign prod[k] = '0;
    end
  end

  // Registered balanced adder tree
  always_ff @(posedge clk) begin
    for (int j = 0; j < LEAVES; j++) lvl[0][j] <= prod[j];
    for (int l = 0; l < LEVELS; l++)
      for (int j = 0; j < LEAVES; j++)
        if (j < (LEAVES >> (l + 1))) lvl[l+1][j] <= lvl[l][2*j] + lvl[l][2*j+1];
        else                         lvl[l+1][j] <= '0;
  end

  assign out_valid = vpipe[LAT-1];
  assign out_data  = lvl[LEVELS][0];

  // Samples accepted but not yet delivered
  logic [PW-1:0] pend;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else        pend <= pend + PW'(in_valid) - PW'(out_valid);

  assert_out_has_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend != '0);
  assert_pipeline_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend) <= LAT);
  assert_idle_holds_history_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(hist[0]) && $stable(hist[TAPS-1]));
  assert_accept_enters_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> hist[0] == $past(in_sample));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_data) <= BOUND) && (longint'(out_data) >= -BOUND));
endmodule

// File: tb/test_sym_csd_fir.sv
module test_sym_csd_fir;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 16;
  localparam int IN_W = 12;
  localparam int CW = 12;
  localparam int HALF = (TAPS + 1) / 2;
  localparam int LAT = 3 + $clog2(HALF);
  localparam int OUT_W = IN_W + CW + 1 + $clog2(HALF);
  localparam int C [HALF] = '{3, -15, 0, 87, -201, -2048, 1023, 2047};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_sample = '0;
  logic ov_s, ov_a;
  logic signed [OUT_W-1:0] od_s, od_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym_csd_fir i_sym_csd_fir (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(ov_s), .out_data(od_s));
  sym_csd_fir #(.ANTISYM(1'b1)) i_sym_csd_fir_anti (.clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sample(in_sample), .out_valid(ov_a), .out_data(od_a));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R1";
  longint hx [TAPS];
  longint exp_s [4096];
  longint exp_a [4096];
  int sendc [4096];
  int wr = 0;
  int rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint hcoef(int k, bit anti);
    int idx;
    idx = (k < HALF) ? k : TAPS - 1 - k;
    if (anti && k >= HALF) return -longint'(C[idx]);
    if (anti && (TAPS % 2 == 0) && k >= TAPS / 2) return -longint'(C[idx]);
    return longint'(C[idx]);
  endfunction

  task automatic check(string req, longint act, longint expv, string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Output monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd < wr && cyc - sendc[rd] > LAT) begin
        check("R1", 0, 1, "missing output");
        rd++;
      end
      if (ov_s || ov_a) begin
        if (rd >= wr) check("R1", 1, 0, "output without sample");
        else begin
          check("R1", longint'(cyc - sendc[rd]), LAT, "latency");
          check("R1", longint'(ov_a), longint'(ov_s), "valid agreement");
          check({"R2/", tag}, longint'(od_s), exp_s[rd], "symmetric result");
          check({"R3/", tag}, longint'(od_a), exp_a[rd], "antisymmetric result");
          rd++;
        end
      end
    end
  end

  task automatic send(int x);
    longint ss, sa;
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = IN_W'(x);
    for (int i = TAPS - 1; i > 0; i--) hx[i] = hx[i-1];
    hx[0] = longint'(x);
    ss = 0;
    sa = 0;
    for (int k = 0; k < TAPS; k++) begin
      ss += hcoef(k, 1'b0) * hx[k];
      sa += hcoef(k, 1'b1) * hx[k];
    end
    exp_s[wr] = ss;
    exp_a[wr] = sa;
    sendc[wr] = cyc;
    wr++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain(string req);
    idle(LAT + 3);
    check(req, longint'(rd), longint'(wr), "all outputs delivered");
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int i = 0; i < TAPS; i++) hx[i] = 0;
    rd = wr;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R6", longint'(ov_s | ov_a), 0, "valid during reset");
    end
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset(3);
    for (int i = 0; i < 2 * LAT; i++) begin
      @(negedge clk);
      check("R6", longint'(ov_s | ov_a), 0, "valid idle after reset");
    end
  endtask

  task automatic t_impulse();
    tag = "R8";
    send(1);
    for (int i = 1; i < TAPS + 2; i++) send(0);
    drain("R8");
  endtask

  task automatic t_full_scale();
    tag = "R7";
    for (int i = 0; i < TAPS + 2; i++) send(2047);
    for (int i = 0; i < TAPS + 2; i++) send(-2048);
    for (int i = 0; i < TAPS; i++) send((i % 2) ? 2047 : -2048);
    drain("R7");
  endtask

  task automatic t_gapped();
    tag = "R4";
    for (int i = 0; i < 60; i++) begin
      send(int'($urandom % 4096) - 2048);
      if ($urandom % 3 == 0) idle(1 + int'($urandom % 4));
    end
    drain("R4");
  endtask

  task automatic t_burst();
    tag = "R9";
    for (int i = 0; i < 80; i++) send(int'($urandom % 4096) - 2048);
    drain("R9");
  endtask

  task automatic t_reset_midstream();
    tag = "R5";
    for (int i = 0; i < 5; i++) send(1000 - 300 * i);
    do_reset(2);
    send(1);
    for (int i = 1; i < TAPS; i++) send(0);
    drain("R5");
  endtask

  initial begin
    for (int i = 0; i < TAPS; i++) hx[i] = 0;
    t_reset_state();
    t_impulse();
    t_full_scale();
    t_gapped();
    t_burst();
    t_reset_midstream();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule